// File: doc/BRIEF.md
# Operand Hazard Controller for a Five-Stage Integer Pipeline

This block watches the source registers of the instruction sitting in the decode stage and compares them against the destinations of the two older instructions in the execute and memory stages. From those comparisons it decides two things.

First, it decides which value each operand should take once the instruction reaches execute. The choices are the register-file read, the result leaving the memory stage, or the result leaving the writeback stage. The decision is made one cycle early and held in a register, so the execute-stage multiplexers see a select that is already settled. Second, it detects a load whose data is needed by the very next instruction. In that case it asks the front end to hold the program counter and the fetch/decode register, and it asks the execute stage to take a bubble.

The register file is assumed to write in the first half of a cycle and read in the second. An instruction in writeback is therefore already visible to decode, and no writeback-stage destination enters the block. Instructions that have been squashed, and bubbles, reach the block with their write-enable cleared.

Top module: `ilk_hazard_ctrl`

## Requirements
- R1: While reset is held and after its release, before any match, every operand select reads 0 (register file).
- R2: `stall_o` is 1 in the same cycle whenever the execute stage holds a load (`ex_we_i`=1, `ex_load_i`=1) with a nonzero destination equal to any decode source.
- R3: `bubble_o` equals `stall_o` in every cycle.
- R4: `stall_o` stays 0 when the execute-stage producer is not a load, has write-enable 0, or targets register 0.
- R5: A nonzero decode source equal to a non-load execute-stage destination with write-enable set gives that operand select 1 (memory-stage result) on the next clock edge.
- R6: A nonzero decode source equal to a memory-stage destination with write-enable set, and not matched in execute, gives select 2 (writeback-stage result) on the next clock edge. This includes loads.
- R7: When both the execute and memory stages write the matched register, the select on the next edge is 1, so the younger producer wins.
- R8: A decode source of register 0 always gives select 0 on the next edge.
- R9: In the cycle after a stall, every select is 0, because the execute stage holds a bubble.
- R10: A source with no match in execute or memory gives select 0 on the next edge. Each operand is decided independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dec_rs_i | input | NUM_SRC*REG_AW | Source register indices of the decode-stage instruction |
| ex_rd_i | input | REG_AW | Destination of the execute-stage instruction |
| ex_we_i | input | 1 | Execute-stage instruction writes a register |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| mem_rd_i | input | REG_AW | Destination of the memory-stage instruction |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| fwd_sel_o | output | NUM_SRC*2 | Registered per-operand select for execute: 0 register file, 1 memory-stage result, 2 writeback-stage result |
| stall_o | output | 1 | Hold PC and the fetch/decode register |
| bubble_o | output | 1 | Load a bubble into the execute stage |

## Verification
The hardest situation to reach is the sequence around a load-use stall. It needs a load and its consumer back to back, then a held decode slot, a bubble, and finally the same consumer finding the load one stage further on, where it must pick the writeback-stage result. The bench therefore models the pipeline itself. It moves destinations from decode to execute to memory, inserts the bubble whenever it expects a stall, and keeps the decode instruction in place. Random sources and destinations are drawn from a small set of registers that includes register 0, so loads collide with their consumers and double producers occur often.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_MEM = 2'd1,
        FWD_WB  = 2'd2
    } fwd_sel_e;

    localparam int FWD_W = 2;
endpackage

// File: rtl/ilk_src_cmp.sv
module ilk_src_cmp #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_i,
    input  logic [REG_AW-1:0] ex_rd_i,
    input  logic              ex_we_i,
    input  logic              ex_load_i,
    input  logic [REG_AW-1:0] mem_rd_i,
    input  logic              mem_we_i,
    output logic              hit_ex_alu_o,
    output logic              hit_ex_load_o,
    output logic              hit_mem_o
);
    logic src_live;
    logic ex_eq;
    logic mem_eq;

    always_comb begin
        src_live      = (src_i != '0);
        ex_eq         = src_live && ex_we_i && (ex_rd_i == src_i);
        mem_eq        = src_live && mem_we_i && (mem_rd_i == src_i);
        hit_ex_alu_o  = ex_eq && !ex_load_i;
        hit_ex_load_o = ex_eq && ex_load_i;
        hit_mem_o     = mem_eq;
    end
endmodule

// File: rtl/ilk_fwd_pick.sv
module ilk_fwd_pick
    import ilk_pkg::*;
(
    input  logic     hit_ex_alu_i,
    input  logic     hit_ex_load_i,
    input  logic     hit_mem_i,
    output fwd_sel_e sel_o,
    output logic     load_use_o
);
    always_comb begin
        load_use_o = hit_ex_load_i;
        if (hit_ex_alu_i) begin
            sel_o = FWD_MEM;
        end else if (hit_mem_i) begin
            sel_o = FWD_WB;
        end else begin
            sel_o = FWD_RF;
        end
    end
endmodule

// File: rtl/ilk_hazard_ctrl.sv
module ilk_hazard_ctrl
    import ilk_pkg::*;
#(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic [NUM_SRC-1:0][REG_AW-1:0] dec_rs_i,
    input  logic [REG_AW-1:0]              ex_rd_i,
    input  logic                           ex_we_i,
    input  logic                           ex_load_i,
    input  logic [REG_AW-1:0]              mem_rd_i,
    input  logic                           mem_we_i,
    output logic [NUM_SRC-1:0][FWD_W-1:0]  fwd_sel_o,
    output logic                           stall_o,
    output logic                           bubble_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0][FWD_W-1:0] sel;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [NUM_SRC-1:0] hit_ex_alu;
    logic [NUM_SRC-1:0] hit_ex_load;
    logic [NUM_SRC-1:0] hit_mem;
    logic [NUM_SRC-1:0] load_use;
    fwd_sel_e           pick [NUM_SRC];

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_opnd
        ilk_src_cmp #(.REG_AW(REG_AW)) u_cmp (
            .src_i         (dec_rs_i[k]),
            .ex_rd_i       (ex_rd_i),
            .ex_we_i       (ex_we_i),
            .ex_load_i     (ex_load_i),
            .mem_rd_i      (mem_rd_i),
            .mem_we_i      (mem_we_i),
            .hit_ex_alu_o  (hit_ex_alu[k]),
            .hit_ex_load_o (hit_ex_load[k]),
            .hit_mem_o     (hit_mem[k])
        );

        ilk_fwd_pick u_pick (
            .hit_ex_alu_i  (hit_ex_alu[k]),
            .hit_ex_load_i (hit_ex_load[k]),
            .hit_mem_i     (hit_mem[k]),
            .sel_o         (pick[k]),
            .load_use_o    (load_use[k])
        );
    end

    logic stall_d;

    always_comb begin
        stall_d = |load_use;
        ctrl_d  = ctrl_q;
        for (int k = 0; k < NUM_SRC; k++) begin
            ctrl_d.sel[k] = stall_d ? FWD_RF : pick[k];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign fwd_sel_o = ctrl_q.sel;
    assign stall_o   = stall_d;
    assign bubble_o  = stall_d;
endmodule

// File: rtl/ilk_hazard_ctrl_chk.sv
module ilk_hazard_ctrl_chk #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input logic                           clk_i,
    input logic                           rst_ni,
    input logic [NUM_SRC-1:0][REG_AW-1:0] dec_rs_i,
    input logic [REG_AW-1:0]              ex_rd_i,
    input logic                           ex_we_i,
    input logic                           ex_load_i,
    input logic [REG_AW-1:0]              mem_rd_i,
    input logic                           mem_we_i,
    input logic [NUM_SRC-1:0][1:0]        fwd_sel_o,
    input logic                           stall_o,
    input logic                           bubble_o
);
    AST_STALL_NEEDS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |-> (ex_we_i && ex_load_i && ex_rd_i != '0)); // R4
    AST_BUBBLE_TRACKS_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bubble_o == stall_o); // R3
    AST_SINGLE_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |=> !stall_o); // R9
    AST_SEL_CLEAR_AFTER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |=> (fwd_sel_o == '0)); // R9

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
        AST_SEL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
            fwd_sel_o[k] != 2'd3); // R10
        AST_ZERO_SRC_RF: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (dec_rs_i[k] == '0) |=> (fwd_sel_o[k] == 2'd0)); // R8
        AST_EX_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!stall_o && dec_rs_i[k] != '0 && ex_we_i && ex_rd_i == dec_rs_i[k])
            |=> (fwd_sel_o[k] == 2'd1)); // R5
        AST_MEM_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!stall_o && dec_rs_i[k] != '0 && mem_we_i && mem_rd_i == dec_rs_i[k]
             && !(ex_we_i && ex_rd_i == dec_rs_i[k]))
            |=> (fwd_sel_o[k] == 2'd2)); // R6
    end
endmodule

bind ilk_hazard_ctrl ilk_hazard_ctrl_chk #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dec_rs_i  (dec_rs_i),
    .ex_rd_i   (ex_rd_i),
    .ex_we_i   (ex_we_i),
    .ex_load_i (ex_load_i),
    .mem_rd_i  (mem_rd_i),
    .mem_we_i  (mem_we_i),
    .fwd_sel_o (fwd_sel_o),
    .stall_o   (stall_o),
    .bubble_o  (bubble_o)
);

// File: tb/sim_ilk_hazard_ctrl.sv
module sim_ilk_hazard_ctrl;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0][4:0] dec_rs;
    logic [4:0]      ex_rd, mem_rd;
    logic            ex_we, ex_load, mem_we;
    logic [1:0][1:0] fwd_sel;
    logic            stall, bubble;

    always #5 clk = ~clk;

    ilk_hazard_ctrl #(.REG_AW(5), .NUM_SRC(2)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .dec_rs_i(dec_rs),
        .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_load_i(ex_load),
        .mem_rd_i(mem_rd), .mem_we_i(mem_we),
        .fwd_sel_o(fwd_sel), .stall_o(stall), .bubble_o(bubble)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // pipeline model: decode slot, execute and memory destinations
    logic [4:0] d_rs1, d_rs2, d_rd;
    logic       d_we, d_ld;
    logic [4:0] m_ex_rd, m_mem_rd;
    logic       m_ex_we, m_ex_ld, m_mem_we;
    logic       prev_stall;
    logic [1:0] exp_sel [2];
    string      exp_tag [2];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic calc_stall(logic [4:0] a, logic [4:0] b);
        return m_ex_we && m_ex_ld && (m_ex_rd != 0) && (a == m_ex_rd || b == m_ex_rd);
    endfunction

    task automatic calc_sel(int k, logic [4:0] rs, logic st);
        logic ex_hit, mem_hit;
        ex_hit  = m_ex_we && (m_ex_rd == rs);
        mem_hit = m_mem_we && (m_mem_rd == rs);
        if (st) begin exp_sel[k] = 2'd0; exp_tag[k] = "R9"; end
        else if (rs == 0) begin exp_sel[k] = 2'd0; exp_tag[k] = "R8"; end
        else if (ex_hit && mem_hit) begin exp_sel[k] = 2'd1; exp_tag[k] = "R7"; end
        else if (ex_hit) begin exp_sel[k] = 2'd1; exp_tag[k] = "R5"; end
        else if (mem_hit) begin exp_sel[k] = 2'd2; exp_tag[k] = "R6"; end
        else begin exp_sel[k] = 2'd0; exp_tag[k] = "R10"; end
    endtask

    // one pipeline cycle; the offered instruction is ignored while decode holds
    task automatic step(logic [4:0] rs1, logic [4:0] rs2, logic [4:0] rd, logic we, logic ld);
        logic st;
        @(negedge clk);
        for (int k = 0; k < 2; k++) check(exp_tag[k], fwd_sel[k], exp_sel[k]);
        m_mem_rd = m_ex_rd; m_mem_we = m_ex_we;
        if (prev_stall) begin
            m_ex_rd = 0; m_ex_we = 0; m_ex_ld = 0;
        end else begin
            m_ex_rd = d_rd; m_ex_we = d_we; m_ex_ld = d_ld;
            d_rs1 = rs1; d_rs2 = rs2; d_rd = rd; d_we = we; d_ld = ld;
        end
        dec_rs[0] = d_rs1; dec_rs[1] = d_rs2;
        ex_rd = m_ex_rd; ex_we = m_ex_we; ex_load = m_ex_ld;
        mem_rd = m_mem_rd; mem_we = m_mem_we;
        #1;
        st = calc_stall(d_rs1, d_rs2);
        check(st ? "R2" : "R4", stall, st);
        check("R3", bubble, stall);
        calc_sel(0, d_rs1, st);
        calc_sel(1, d_rs2, st);
        prev_stall = st;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        dec_rs = '0; ex_rd = 0; ex_we = 0; ex_load = 0; mem_rd = 0; mem_we = 0;
        d_rs1 = 0; d_rs2 = 0; d_rd = 0; d_we = 0; d_ld = 0;
        m_ex_rd = 0; m_ex_we = 0; m_ex_ld = 0; m_mem_rd = 0; m_mem_we = 0;
        prev_stall = 0;
        for (int k = 0; k < 2; k++) begin exp_sel[k] = 0; exp_tag[k] = "R1"; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", fwd_sel, 0);
        rst_n = 1'b1;

        // ALU producer then consumer: forward from memory stage, no stall
        step(5'd2, 5'd3, 5'd1, 1, 0);
        step(5'd1, 5'd4, 5'd5, 1, 0);
        step(5'd0, 5'd0, 5'd0, 0, 0);
        // load then immediate use: one stall, then writeback-stage select
        step(5'd6, 5'd7, 5'd2, 1, 1);
        step(5'd9, 5'd2, 5'd8, 1, 0);
        step(5'd9, 5'd2, 5'd8, 1, 0);
        step(5'd0, 5'd0, 5'd0, 0, 0);
        step(5'd0, 5'd0, 5'd0, 0, 0);
        // load to register 0 and a consumer of register 0
        step(5'd1, 5'd1, 5'd0, 1, 1);
        step(5'd0, 5'd0, 5'd3, 1, 0);
        // two producers of the same register, then consumer
        step(5'd1, 5'd1, 5'd4, 1, 0);
        step(5'd1, 5'd1, 5'd4, 1, 0);
        step(5'd4, 5'd4, 5'd5, 1, 0);
        // killed load (write-enable clear) does not stall
        step(5'd0, 5'd0, 5'd6, 0, 1);
        step(5'd6, 5'd0, 5'd7, 1, 0);
        step(5'd0, 5'd0, 5'd0, 0, 0);

        for (int i = 0; i < 4000; i++) begin
            step(5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)),
                 5'($urandom_range(0, 7)), 1'($urandom_range(0, 3) != 0),
                 1'($urandom_range(0, 3) == 0));
        end
        step(5'd0, 5'd0, 5'd0, 0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule